// File: doc/BRIEF.md
# Banked DMA Channel Register File

This block is the control and status register file of a 20-channel DMA engine. Software reaches all per-channel state through one window. A channel-select register chooses which channel's bank answers accesses to the per-channel offsets. Those registers are polling, control, descriptor base, descriptor count, interrupt status and interrupt enable. A port-select register chooses the bank behind a single port-control offset in the same way. A global interrupt-enable register holds one bit per channel. A read-only identification word reports the revision and the sizes.

The data path of the engine is not part of this block. Single-cycle event inputs, one per channel, stand in for descriptor completion. The block keeps the interrupt status sticky until software clears it by writing ones. It runs the fixed-length channel reset that software starts and then polls. It combines all enabled status into one interrupt line.

Bus writes take effect at the clock edge where `bus_wr` is high. Read data is combinational from the address and the register state.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset, every channel register, the select registers, the port-control registers and the global interrupt enable read 0, and `irq_o` is low.
- R2: Offset 0x08 reads a constant: revision (default 1) in bits 4:0, port count (default 4) in bits 19:16 and channel count (default 20) in bits 31:20. With the defaults the value is 0x01440001.
- R3: Offset 0x18 holds the channel number last written to it and reads it back. Offsets 0x14, 0x1C, 0x20, 0x24, 0x28 and 0x2C read and write only the bank of that channel.
- R4: Channel control at 0x1C stores the on bit (bit 0), the transmit bit (bit 8) and a two-bit weight (bits 17:16). All its other bits read 0.
- R5: Writing channel control with bit 1 set starts a channel reset. Bit 1 reads 1 in the 4 cycles after the write and 0 from then on. From the write onward the on bit and the status of that channel read 0. Events that arrive during the reset are dropped.
- R6: Bit 3 of interrupt status at 0x28 is set by a one-cycle pulse on that channel's event input. Writing a 1 to bit 3 clears it; both 0x08 and 0x7E do. Writing 0 to bit 3 leaves it unchanged. An event in the same cycle as a clearing write leaves the bit set.
- R7: `irq_o` is high whenever some channel n has status bit 3 set, interrupt enable bit 3 (at 0x2C) set, and bit n of the global enable set. `irq_o` follows the register state within the same cycle.
- R8: The global interrupt enable at 0xF4 stores one bit per channel, bit n for channel n. Bits 20 and above read 0.
- R9: While the channel select holds 20 or more, writes to the per-channel offsets change nothing and reads of them return 0.
- R10: Port select at 0x40 chooses one of 4 banks of a 32-bit port control at 0x44. A port select of 4 or more makes writes to 0x44 change nothing and reads of 0x44 return 0.
- R11: A write to 0x10 with bit 0 set clears every register of the block, including any reset in progress. Offset 0x10 always reads 0.
- R12: The polling register at 0x14 stores only bit 31 (polling on) and bit 6 (divide-by-4). Descriptor count at 0x24 stores its low 16 bits. Descriptor base at 0x20 stores all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| chan_done_evt | input | 20 | Per-channel descriptor-complete pulse |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume a few things about the inputs. Reads and writes never happen in the same cycle, and addresses are word offsets. A clear of the whole engine is not started in the same cycle as a channel reset it would cancel. That cancelled reset is the one case the reset-length property leaves out. The stimulus makes one bus access per clock and drives every input midway between edges. It raises a channel event only for a single cycle. Events that must collide with a write or with a reset are set up so that they share one edge with that write, or fall inside the reset window.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_IDENT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_GCTL  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_POLL  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CSEL  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CCTL  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_DBASE = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_DCNT  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_ISTAT = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_PSEL  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_PCTL  = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_GIEN  = 8'hF4;

  localparam int CC_ON    = 0;
  localparam int CC_RST   = 1;
  localparam int CC_TX    = 8;
  localparam int CC_WGT   = 16;
  localparam int PL_EN    = 31;
  localparam int PL_DIV4  = 6;
  localparam int IRQ_DESC = 3;
  localparam int GC_CLEAR = 0;

  typedef struct packed {
    logic [DATA_W-1:0] poll;
    logic [DATA_W-1:0] ctrl;
    logic [DATA_W-1:0] dbase;
    logic [DATA_W-1:0] dcnt;
    logic [DATA_W-1:0] istat;
    logic [DATA_W-1:0] ien;
  } chan_view_t;

  function automatic logic is_chan_ofs(input logic [ADDR_W-1:0] a);
    return (a == OFS_POLL) || (a == OFS_CCTL) || (a == OFS_DBASE) ||
           (a == OFS_DCNT) || (a == OFS_ISTAT) || (a == OFS_IEN);
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_csr_pkg::*;
#(
  parameter int DCNT_W  = 16,
  parameter int IEN_W   = 8,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_ofs,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done_evt,
  output chan_view_t        view,
  output logic              irq_req
);
  localparam int CNT_W = $clog2(RST_CYC + 1);

  logic              on_q, on_d, tx_q, tx_d, busy_q, busy_d;
  logic [1:0]        wgt_q, wgt_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pen_q, pen_d, pdiv_q, pdiv_d;
  logic [DATA_W-1:0] dbase_q, dbase_d;
  logic [DCNT_W-1:0] dcnt_q, dcnt_d;
  logic              stat_q, stat_d;
  logic [IEN_W-1:0]  ien_q, ien_d;
  logic              wr_cctl, rst_go, clr_hit;

  assign wr_cctl = wr_en && (wr_ofs == OFS_CCTL);
  assign rst_go  = wr_cctl && wdata[CC_RST];
  assign clr_hit = wr_en && (wr_ofs == OFS_ISTAT) && wdata[IRQ_DESC];

  always_comb begin
    on_d = on_q; tx_d = tx_q; wgt_d = wgt_q; busy_d = busy_q; cnt_d = cnt_q;
    pen_d = pen_q; pdiv_d = pdiv_q; dbase_d = dbase_q; dcnt_d = dcnt_q;
    stat_d = stat_q; ien_d = ien_q;
    if (soft_clr) begin
      on_d = 1'b0; tx_d = 1'b0; wgt_d = '0; busy_d = 1'b0; cnt_d = '0;
      pen_d = 1'b0; pdiv_d = 1'b0; dbase_d = '0; dcnt_d = '0;
      stat_d = 1'b0; ien_d = '0;
    end else begin
      if (wr_cctl) begin
        on_d  = wdata[CC_ON];
        tx_d  = wdata[CC_TX];
        wgt_d = wdata[CC_WGT+1:CC_WGT];
      end
      if (rst_go) begin
        busy_d = 1'b1;
        cnt_d  = CNT_W'(RST_CYC - 1);
        on_d   = 1'b0;
      end else if (busy_q) begin
        on_d = 1'b0;
        if (cnt_q == '0) busy_d = 1'b0;
        else             cnt_d  = cnt_q - 1'b1;
      end
      if (rst_go || busy_q) stat_d = 1'b0;
      else                  stat_d = (stat_q && !clr_hit) || done_evt;
      if (wr_en && wr_ofs == OFS_POLL) begin
        pen_d  = wdata[PL_EN];
        pdiv_d = wdata[PL_DIV4];
      end
      if (wr_en && wr_ofs == OFS_DBASE) dbase_d = wdata;
      if (wr_en && wr_ofs == OFS_DCNT)  dcnt_d  = wdata[DCNT_W-1:0];
      if (wr_en && wr_ofs == OFS_IEN)   ien_d   = wdata[IEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0; tx_q <= 1'b0; wgt_q <= '0; busy_q <= 1'b0; cnt_q <= '0;
      pen_q <= 1'b0; pdiv_q <= 1'b0; dbase_q <= '0; dcnt_q <= '0;
      stat_q <= 1'b0; ien_q <= '0;
    end else begin
      on_q <= on_d; tx_q <= tx_d; wgt_q <= wgt_d; busy_q <= busy_d; cnt_q <= cnt_d;
      pen_q <= pen_d; pdiv_q <= pdiv_d; dbase_q <= dbase_d; dcnt_q <= dcnt_d;
      stat_q <= stat_d; ien_q <= ien_d;
    end
  end

  always_comb begin
    view = '0;
    view.poll[PL_EN]              = pen_q;
    view.poll[PL_DIV4]            = pdiv_q;
    view.ctrl[CC_ON]              = on_q;
    view.ctrl[CC_RST]             = busy_q;
    view.ctrl[CC_TX]              = tx_q;
    view.ctrl[CC_WGT+1:CC_WGT]    = wgt_q;
    view.dbase                    = dbase_q;
    view.dcnt[DCNT_W-1:0]         = dcnt_q;
    view.istat[IRQ_DESC]          = stat_q;
    view.ien[IEN_W-1:0]           = ien_q;
  end

  assign irq_req = stat_q && ien_q[IRQ_DESC];

  // Length of each completed reset, counted independently of cnt_q.
  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_q <= '0;
    else if (rst_go || soft_clr)  run_q <= '0;
    else if (busy_q)              run_q <= run_q + 1'b1;
    else                          run_q <= '0;
  end

  assert_rst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !$past(soft_clr)) |-> (run_q == CNT_W'(RST_CYC)));

  assert_quiet_in_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (!on_q && !stat_q));

  assert_evt_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !busy_q && !rst_go && !soft_clr) |=> stat_q);
endmodule

// File: rtl/dma_port_bank.sv
module dma_port_bank
  import dma_csr_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              wr_en,
  input  logic [7:0]        psel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] pctl_q [NPORT];
  logic [DATA_W-1:0] pctl_d [NPORT];

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    always_comb begin
      pctl_d[g] = pctl_q[g];
      if (soft_clr)                         pctl_d[g] = '0;
      else if (wr_en && psel == 8'(g))      pctl_d[g] = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pctl_q[g] <= '0;
      else        pctl_q[g] <= pctl_d[g];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NPORT; i++)
      if (psel == 8'(i)) rdata = pctl_q[i];
  end
endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge #(
  parameter int NCH = 20
) (
  input  logic [NCH-1:0] chan_req,
  input  logic [NCH-1:0] chan_gate,
  output logic           irq
);
  assign irq = |(chan_req & chan_gate);
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int NCH     = 20,
  parameter int NPORT   = 4,
  parameter int HW_REV  = 1,
  parameter int DCNT_W  = 16,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    chan_done_evt,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] IDENT_VAL =
    {12'(NCH), 4'(NPORT), 11'b0, 5'(HW_REV)};

  logic [7:0]     csel_q, csel_d, psel_q, psel_d;
  logic [NCH-1:0] gien_q, gien_d, chan_req;
  logic           soft_clr, chan_acc;
  chan_view_t     views [NCH];
  chan_view_t     cur;
  logic [DATA_W-1:0] port_rd;

  assign soft_clr = bus_wr && (bus_addr == OFS_GCTL) && bus_wdata[GC_CLEAR];
  assign chan_acc = is_chan_ofs(bus_addr);

  always_comb begin
    csel_d = csel_q; psel_d = psel_q; gien_d = gien_q;
    if (soft_clr) begin
      csel_d = '0; psel_d = '0; gien_d = '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_CSEL) csel_d = bus_wdata[7:0];
      if (bus_addr == OFS_PSEL) psel_d = bus_wdata[7:0];
      if (bus_addr == OFS_GIEN) gien_d = bus_wdata[NCH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel_q <= '0; psel_q <= '0; gien_q <= '0;
    end else begin
      csel_q <= csel_d; psel_q <= psel_d; gien_q <= gien_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_chan_regs #(.DCNT_W(DCNT_W), .IEN_W(8), .RST_CYC(RST_CYC)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .wr_en    (bus_wr && chan_acc && (csel_q == 8'(g))),
      .wr_ofs   (bus_addr),
      .wdata    (bus_wdata),
      .done_evt (chan_done_evt[g]),
      .view     (views[g]),
      .irq_req  (chan_req[g])
    );
  end

  dma_port_bank #(.NPORT(NPORT)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .wr_en    (bus_wr && (bus_addr == OFS_PCTL)),
    .psel     (psel_q),
    .wdata    (bus_wdata),
    .rdata    (port_rd)
  );

  dma_irq_merge #(.NCH(NCH)) u_irq (
    .chan_req  (chan_req),
    .chan_gate (gien_q),
    .irq       (irq_o)
  );

  always_comb begin
    cur = '0;
    for (int i = 0; i < NCH; i++)
      if (csel_q == 8'(i)) cur = views[i];
  end

  always_comb begin
    unique case (bus_addr)
      OFS_IDENT: bus_rdata = IDENT_VAL;
      OFS_POLL:  bus_rdata = cur.poll;
      OFS_CSEL:  bus_rdata = 32'(csel_q);
      OFS_CCTL:  bus_rdata = cur.ctrl;
      OFS_DBASE: bus_rdata = cur.dbase;
      OFS_DCNT:  bus_rdata = cur.dcnt;
      OFS_ISTAT: bus_rdata = cur.istat;
      OFS_IEN:   bus_rdata = cur.ien;
      OFS_PSEL:  bus_rdata = 32'(psel_q);
      OFS_PCTL:  bus_rdata = port_rd;
      OFS_GIEN:  bus_rdata = 32'(gien_q);
      default:   bus_rdata = '0;
    endcase
  end

  assert_no_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && chan_acc && (csel_q >= 8'(NCH))) |-> (bus_rdata == '0));
endmodule

// File: tb/dma_csr_bank_test.sv
module dma_csr_bank_test;
  localparam int NCH = 20;
  localparam logic [7:0] A_ID = 8'h08, A_GCTL = 8'h10, A_POLL = 8'h14,
    A_CSEL = 8'h18, A_CCTL = 8'h1C, A_DBASE = 8'h20, A_DCNT = 8'h24,
    A_ISTAT = 8'h28, A_IEN = 8'h2C, A_PSEL = 8'h40, A_PCTL = 8'h44,
    A_GIEN = 8'hF4;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, irq_o;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] chan_done_evt = '0;
  int checks = 0, errors = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb [$];

  always #2 clk = ~clk;

  dma_csr_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_done_evt(chan_done_evt), .irq_o(irq_o));

  // Monitor: compares each read against the queued expectation.
  always @(negedge clk) begin
    if (bus_rd) begin
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expectation");
      end else begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int ch);
    chan_done_evt[ch] = 1'b1;
    @(posedge clk); #1;
    chan_done_evt[ch] = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s: irq got %b expected %b", tag, irq_o, e);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(A_CCTL, 32'h0, "R1 ctrl");
    rd(A_GIEN, 32'h0, "R1 gien");
    rd(A_CSEL, 32'h0, "R1 csel");
    rd(A_PCTL, 32'h0, "R1 pctl");
    chk_irq(1'b0, "R1 irq");
    // R2 identification
    rd(A_ID, 32'h0144_0001, "R2 ident");
    // R3 bank steering
    wr(A_CSEL, 5); wr(A_DBASE, 32'h1234_5678);
    wr(A_CSEL, 6); wr(A_DBASE, 32'hCAFE_0000);
    rd(A_DBASE, 32'hCAFE_0000, "R3 bank6");
    wr(A_CSEL, 5);
    rd(A_DBASE, 32'h1234_5678, "R3 bank5");
    rd(A_CSEL, 32'd5, "R3 csel");
    // R12 field widths
    wr(A_POLL, 32'hFFFF_FFFF);
    rd(A_POLL, 32'h8000_0040, "R12 poll");
    wr(A_DCNT, 32'h0001_0040);
    rd(A_DCNT, 32'h0000_0040, "R12 dcnt");
    // R4 control fields
    wr(A_CCTL, 32'hFFFF_FFFD);
    rd(A_CCTL, 32'h0003_0101, "R4 ctrl");
    // R5 channel reset
    pulse(5);
    rd(A_ISTAT, 32'h8, "R6 evt set");
    wr(A_CCTL, 32'h3);
    rd(A_ISTAT, 32'h0, "R5 stat cleared");
    chan_done_evt[5] = 1'b1;
    rd(A_CCTL, 32'h2, "R5 busy1");
    chan_done_evt[5] = 1'b0;
    rd(A_CCTL, 32'h2, "R5 busy2");
    rd(A_CCTL, 32'h2, "R5 busy3");
    rd(A_CCTL, 32'h0, "R5 done");
    rd(A_ISTAT, 32'h0, "R5 evt dropped");
    // R6 write-one-to-clear
    pulse(5);
    wr(A_ISTAT, 32'h0);
    rd(A_ISTAT, 32'h8, "R6 zero write");
    wr(A_ISTAT, 32'h7E);
    rd(A_ISTAT, 32'h0, "R6 ack");
    pulse(5);
    chan_done_evt[5] = 1'b1;
    wr(A_ISTAT, 32'h8);
    chan_done_evt[5] = 1'b0;
    rd(A_ISTAT, 32'h8, "R6 collide");
    // R7 interrupt combine
    chk_irq(1'b0, "R7 no enables");
    wr(A_IEN, 32'h8);
    chk_irq(1'b0, "R7 no global");
    wr(A_GIEN, 32'h20);
    chk_irq(1'b1, "R7 asserted");
    rd(A_IEN, 32'h8, "R7 ien");
    wr(A_GIEN, 32'h10);
    chk_irq(1'b0, "R7 other channel");
    wr(A_GIEN, 32'h20);
    wr(A_ISTAT, 32'h7E);
    chk_irq(1'b0, "R7 acked");
    // R8 global enable width
    wr(A_GIEN, 32'hFFFF_FFFF);
    rd(A_GIEN, 32'h000F_FFFF, "R8 gien");
    // R9 out of range channel
    wr(A_CSEL, 20);
    wr(A_DBASE, 32'hDEAD_BEEF);
    rd(A_DBASE, 32'h0, "R9 read zero");
    rd(A_CSEL, 32'd20, "R9 csel");
    wr(A_CSEL, 5);
    rd(A_DBASE, 32'h1234_5678, "R9 bank5 intact");
    wr(A_CSEL, 19); wr(A_DCNT, 32'h7);
    rd(A_DCNT, 32'h7, "R3 last bank");
    // R10 port banks
    wr(A_PSEL, 1); wr(A_PCTL, 32'h0000_ABCD);
    wr(A_PSEL, 2);
    rd(A_PCTL, 32'h0, "R10 port2");
    wr(A_PSEL, 1);
    rd(A_PCTL, 32'h0000_ABCD, "R10 port1");
    wr(A_PSEL, 4); wr(A_PCTL, 32'h55);
    rd(A_PCTL, 32'h0, "R10 no port");
    wr(A_PSEL, 3);
    rd(A_PCTL, 32'h0, "R10 port3 intact");
    // R11 engine clear
    wr(A_GCTL, 32'h1);
    rd(A_GCTL, 32'h0, "R11 gctl");
    rd(A_GIEN, 32'h0, "R11 gien");
    rd(A_CSEL, 32'h0, "R11 csel");
    wr(A_PSEL, 1);
    rd(A_PCTL, 32'h0, "R11 pctl");
    wr(A_CSEL, 5);
    rd(A_DBASE, 32'h0, "R11 dbase");

    @(posedge clk); #1;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d reads not compared", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule